// File: doc/BRIEF.md
# Four-Register Instruction Datapath

This block is a small 4-bit execution datapath. It holds four general registers and runs one instruction every clock cycle. Each instruction is a 3-bit opcode plus two 2-bit register fields, written here as `aa` (field A) and `bb` (field B). A combinational control decoder turns each instruction into the controls for the register file: two read addresses, a write address and a write enable. It also produces an ALU operation and a select that picks the written value from either the ALU result or the external memory input.

Sequencing is done elsewhere. A controller or a bench supplies the instruction stream. The datapath returns two things: a registered memory-output value, and a zero indication that reflects the ALU result of the instruction currently being presented.

Top module: `quad_reg_datapath`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, all four registers and `mem_out` become 0.
- R2: Opcode 3'b001 (set) writes the constant 1 into R[aa].
- R3: Opcode 3'b010 (incr) writes R[aa]+1 into R[aa], and opcode 3'b011 (decr) writes R[aa]-1 into R[aa]. Both work modulo 16, so 15 increments to 0 and 0 decrements to 15.
- R4: Opcode 3'b100 (load) writes `mem_in` into R[aa].
- R5: Opcode 3'b110 (add) writes (R[aa]+R[bb]) mod 16 into R[aa]. This includes the case aa equal to bb, which doubles the register.
- R6: Opcode 3'b111 (copy) writes R[bb] into R[aa].
- R7: Opcode 3'b101 (store) loads R[aa] into `mem_out` at the clock edge and writes no register. For every other opcode, `mem_out` keeps its value.
- R8: Opcode 3'b000 (noop) changes no register and does not change `mem_out`.
- R9: `zero_flag` is 1 exactly when the ALU result of the current instruction is 0, within the same cycle. The ALU result is as follows:
  - set: 1.
  - incr, decr and add: the value being written.
  - copy: R[bb].
  - noop, load and store: R[aa].
- R10: Each instruction reads register values that include all writes made at earlier clock edges. An instruction that reads a register written by the previous instruction sees the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 3 | Instruction operation code |
| opnd_a | input | 2 | Register field A (destination / first source) |
| opnd_b | input | 2 | Register field B (second source) |
| mem_in | input | 4 | Value written by the load instruction |
| mem_out | output | 4 | Registered value written by the store instruction |
| zero_flag | output | 1 | ALU result of the current instruction equals zero |

## Verification
Within a single cycle, the zero indication and the register write both come from the same ALU result. The flag is judged before the edge, and the written value is judged after it.

This is provoked in two ways. Decrements are driven down from 1, and increments are driven up from 15, so that the value being written is zero while the flag must already be high. Back-to-back dependent instructions then read a register one cycle after it was written.

The bench predicts both the flag and the later store output from a register model of its own. Random instruction streams widen the coverage of these collisions.

// File: rtl/qrd_pkg.sv
// Package: shared opcode encoding and decoder control bundle for the
// four-register datapath. Assumes a 3-bit opcode space fully populated.
package qrd_pkg;

    typedef enum logic [2:0] {
        OP_NOOP  = 3'b000,
        OP_SET   = 3'b001,
        OP_INCR  = 3'b010,
        OP_DECR  = 3'b011,
        OP_LOAD  = 3'b100,
        OP_STORE = 3'b101,
        OP_ADD   = 3'b110,
        OP_COPY  = 3'b111
    } op_e;

endpackage

// File: rtl/qrd_decoder.sv
// Module: qrd_decoder
// Purely combinational control decoder. Maps one instruction word onto
// register-file port controls, the ALU operation and the write-source
// select. Assumes the ALU operation encoding equals the opcode encoding.
module qrd_decoder
    import qrd_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [2:0]        opcode,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    output logic [ADDR_W-1:0] rd1_addr,
    output logic [ADDR_W-1:0] rd2_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_en,
    output logic              sel_mem,
    output op_e               alu_op
);

    // Decode the opcode into port controls.
    always_comb begin
        alu_op   = op_e'(opcode);
        rd2_addr = opnd_b;
        wr_addr  = opnd_a;
        rd1_addr = (opcode == OP_COPY) ? opnd_b : opnd_a;
        wr_en    = !((opcode == OP_NOOP) || (opcode == OP_STORE));
        sel_mem  = (opcode == OP_LOAD);
    end

endmodule

// File: rtl/qrd_regfile.sv
// Module: qrd_regfile
// General register file with one synchronous write port and two
// combinational read ports. Reads see state after the last edge only
// (no write-through). Synchronous active-low reset clears every entry.
module qrd_regfile #(
    parameter int DATA_W = 4,
    parameter int REG_N  = 4,
    localparam int ADDR_W = $clog2(REG_N)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd1_addr,
    input  logic [ADDR_W-1:0]            rd2_addr,
    output logic [DATA_W-1:0]            rd1_data,
    output logic [DATA_W-1:0]            rd2_data,
    output logic [REG_N-1:0][DATA_W-1:0] regs
);

    for (genvar g = 0; g < REG_N; g++) begin : g_reg
        // Hold one register; load it when addressed by an enabled write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    // Combinational read ports.
    always_comb begin
        rd1_data = regs[rd1_addr];
        rd2_data = regs[rd2_addr];
    end

endmodule

// File: rtl/qrd_alu.sv
// Module: qrd_alu
// Combinational ALU. One shared adder with a selectable second operand
// and carry-in serves incr (A+0+1), decr (A+all-ones) and add (A+B).
// Arithmetic wraps modulo 2**DATA_W. Pass-through ops return operand A.
module qrd_alu
    import qrd_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  op_e               alu_op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result,
    output logic              is_zero
);

    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic [DATA_W-1:0] sum;

    // Choose adder second operand and carry-in per operation.
    always_comb begin
        add_b   = '0;
        add_cin = 1'b0;
        case (alu_op)
            OP_INCR: add_cin = 1'b1;
            OP_DECR: add_b   = '1;
            OP_ADD:  add_b   = opb;
            default: add_b   = '0;
        endcase
    end

    // Shared modular adder.
    always_comb sum = opa + add_b + DATA_W'(add_cin);

    // Select the final ALU output and detect zero.
    always_comb begin
        case (alu_op)
            OP_SET:                   result = DATA_W'(1);
            OP_INCR, OP_DECR, OP_ADD: result = sum;
            default:                  result = opa;
        endcase
        is_zero = (result == '0);
    end

endmodule

// File: rtl/quad_reg_datapath.sv
// Module: quad_reg_datapath (top)
// Single-cycle datapath: decoder, register file, ALU, write-source mux and
// a store-output register. One instruction per clock; no sequencing.
// Assumes inputs are stable before each rising edge.
module quad_reg_datapath
    import qrd_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int REG_N  = 4,
    localparam int ADDR_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        opcode,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] mem_in,
    output logic [DATA_W-1:0] mem_out,
    output logic              zero_flag
);

    logic [ADDR_W-1:0]            rd1_addr;
    logic [ADDR_W-1:0]            rd2_addr;
    logic [ADDR_W-1:0]            wr_addr;
    logic                         wr_en;
    logic                         sel_mem;
    op_e                          alu_op;
    logic [DATA_W-1:0]            rd1_data;
    logic [DATA_W-1:0]            rd2_data;
    logic [DATA_W-1:0]            alu_res;
    logic [DATA_W-1:0]            wr_data;
    logic [REG_N-1:0][DATA_W-1:0] reg_q;

    qrd_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .opcode   (opcode),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .rd1_addr (rd1_addr),
        .rd2_addr (rd2_addr),
        .wr_addr  (wr_addr),
        .wr_en    (wr_en),
        .sel_mem  (sel_mem),
        .alu_op   (alu_op)
    );

    qrd_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd1_addr (rd1_addr),
        .rd2_addr (rd2_addr),
        .rd1_data (rd1_data),
        .rd2_data (rd2_data),
        .regs     (reg_q)
    );

    qrd_alu #(.DATA_W(DATA_W)) u_alu (
        .alu_op  (alu_op),
        .opa     (rd1_data),
        .opb     (rd2_data),
        .result  (alu_res),
        .is_zero (zero_flag)
    );

    // Pick the register write source: memory input or ALU result.
    always_comb wr_data = sel_mem ? mem_in : alu_res;

    // Capture the store value; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_out <= '0;
        end else if (opcode == OP_STORE) begin
            mem_out <= rd1_data;
        end
    end

endmodule

// File: rtl/qrd_checker.sv
// Module: qrd_checker
// Property checker for quad_reg_datapath, attached by bind below.
module qrd_checker
    import qrd_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int REG_N  = 4,
    localparam int ADDR_W = $clog2(REG_N)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [2:0]                   opcode,
    input logic [ADDR_W-1:0]            opnd_a,
    input logic [DATA_W-1:0]            mem_in,
    input logic [DATA_W-1:0]            mem_out,
    input logic                         zero_flag,
    input logic [DATA_W-1:0]            rd1_data,
    input logic [REG_N-1:0][DATA_W-1:0] reg_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (mem_out == '0) && (reg_q == '0));

    // R7
    store_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_STORE) |=> (mem_out == $past(rd1_data)));

    // R7
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != OP_STORE) |=> $stable(mem_out));

    // R8
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == OP_NOOP) || (opcode == OP_STORE)) |=> $stable(reg_q));

    // R2
    set_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_SET) |-> !zero_flag);

    // R4
    load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_LOAD) |=> (reg_q[$past(opnd_a)] == $past(mem_in)));

    // R9
    decr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == OP_DECR) && (rd1_data == DATA_W'(1))) |-> zero_flag);

endmodule

bind quad_reg_datapath qrd_checker #(.DATA_W(DATA_W), .REG_N(REG_N)) u_qrd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .opnd_a    (opnd_a),
    .mem_in    (mem_in),
    .mem_out   (mem_out),
    .zero_flag (zero_flag),
    .rd1_data  (rd1_data),
    .reg_q     (reg_q)
);

// File: tb/quad_reg_datapath_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random instruction streams,
// checked against a bench-side register model.
module quad_reg_datapath_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] opcode;
    logic [1:0] opnd_a;
    logic [1:0] opnd_b;
    logic [3:0] mem_in;
    logic [3:0] mem_out;
    logic       zero_flag;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_reg [4];
    logic [3:0] m_mem;

    always #5 clk = ~clk;

    quad_reg_datapath u_quad_reg_datapath (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .mem_in(mem_in), .mem_out(mem_out),
        .zero_flag(zero_flag)
    );

    function automatic logic [3:0] ref_alu(input logic [2:0] op,
                                           input logic [1:0] a, input logic [1:0] b);
        case (op)
            3'b001: return 4'd1;
            3'b010: return m_reg[a] + 4'd1;
            3'b011: return m_reg[a] - 4'd1;
            3'b110: return m_reg[a] + m_reg[b];
            3'b111: return m_reg[b];
            default: return m_reg[a];
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'b000: return "R8";
            3'b001: return "R2";
            3'b010, 3'b011: return "R3";
            3'b100: return "R4";
            3'b101: return "R7";
            3'b110: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One instruction: check zero_flag before the edge, mem_out after it.
    task automatic run(input logic [2:0] op, input logic [1:0] a,
                       input logic [1:0] b, input logic [3:0] din);
        logic [3:0] res;
        @(negedge clk);
        opcode = op; opnd_a = a; opnd_b = b; mem_in = din;
        #1;
        res = ref_alu(op, a, b);
        check("R9 zero_flag", {3'b0, zero_flag}, {3'b0, (res == 4'd0)});
        @(posedge clk);
        if (op == 3'b101) m_mem = m_reg[a];
        else if (op == 3'b100) m_reg[a] = din;
        else if (op != 3'b000) m_reg[a] = res;
        #1;
        check({tag_of(op), " mem_out"}, mem_out, m_mem);
    endtask

    // Store a register and check it explicitly under a named requirement.
    task automatic peek(input string tag, input logic [1:0] a, input logic [3:0] exp);
        run(3'b101, a, 2'd0, 4'd0);
        check(tag, mem_out, exp);
    endtask

    initial begin
        int unsigned seed;
        rst_n = 1'b0; opcode = 3'b0; opnd_a = 2'd0; opnd_b = 2'd0; mem_in = 4'd0;
        for (int i = 0; i < 4; i++) m_reg[i] = 4'd0;
        m_mem = 4'd0;
        // Dirty state first, then reset must clear it.
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        run(3'b100, 2'd2, 2'd0, 4'd9);
        run(3'b101, 2'd2, 2'd0, 4'd0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        for (int i = 0; i < 4; i++) m_reg[i] = 4'd0;
        m_mem = 4'd0;
        check("R1 mem_out after reset", mem_out, 4'd0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 4; i++) peek("R1 register after reset", 2'(i), 4'd0);

        // R2 set, R5 add, R6 copy
        run(3'b001, 2'd1, 2'd0, 4'd0);
        peek("R2 set", 2'd1, 4'd1);
        run(3'b001, 2'd2, 2'd0, 4'd0);
        run(3'b110, 2'd1, 2'd2, 4'd0);
        peek("R5 add", 2'd1, 4'd2);
        run(3'b110, 2'd1, 2'd1, 4'd0);
        peek("R5 add self doubling", 2'd1, 4'd4);
        run(3'b111, 2'd3, 2'd1, 4'd0);
        peek("R6 copy", 2'd3, 4'd4);
        // R3 wrap both ways; zero flag on the writing cycle
        run(3'b100, 2'd0, 2'd0, 4'd15);
        peek("R4 load", 2'd0, 4'd15);
        run(3'b010, 2'd0, 2'd0, 4'd0);
        peek("R3 incr wrap", 2'd0, 4'd0);
        run(3'b011, 2'd0, 2'd0, 4'd0);
        peek("R3 decr wrap", 2'd0, 4'd15);
        run(3'b100, 2'd2, 2'd0, 4'd1);
        run(3'b011, 2'd2, 2'd0, 4'd0);
        peek("R3 decr to zero", 2'd2, 4'd0);
        // R10 back-to-back dependency: load then incr then add
        run(3'b100, 2'd3, 2'd0, 4'd6);
        run(3'b010, 2'd3, 2'd0, 4'd0);
        run(3'b110, 2'd3, 2'd3, 4'd0);
        peek("R10 read after write", 2'd3, 4'd14);
        // R8 noop leaves state and mem_out
        run(3'b000, 2'd3, 2'd1, 4'd5);
        check("R8 noop mem_out held", mem_out, 4'd14);
        peek("R8 noop register kept", 2'd3, 4'd14);

        // Random streams
        seed = $urandom(32'd4242);
        for (int i = 0; i < 400; i++)
            run(3'($urandom), 2'($urandom), 2'($urandom), 4'($urandom));
        for (int i = 0; i < 4; i++) peek("R10 random final state", 2'(i), m_reg[i]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule